// File: doc/BRIEF.md
# Limp-Home Clock Supervisor

This block decides which clock the core runs from after a reset and after leaving stop mode, and it keeps watching the crystal oscillator. It runs on the free-running VCO clock, which never stops. When the crystal shows no activity and the fallback is allowed, it selects the VCO clock and raises a limp-home flag. While in that fallback it samples the crystal activity on a fixed schedule: one check a first interval after entry, then one check per longer recheck interval. Only a run of good checks brings it back to the crystal.

Every reset and every delayed stop exit starts an internal release counter. The core is held until the counter completes. Crystal activity seen during that count clears the fallback flag before the core starts. A watchdog reset repeats the counted sequence but keeps the current clock choice, because the oscillator keeps running through it. The crystal activity line is asynchronous and passes through a synchronizer before any decision uses it.

Top module: `limp_clk_supervisor`

## Requirements
- R1: While the power-on or external reset input is high, run_o is 0 one edge later, and limp_o and sel_vco_o equal the limp-allowed condition (pll_supply_i high and lh_disable_i low).
- R2: After the last reset input falls, run_o rises on the STARTUP_CYC-th rising edge. If synchronized activity is seen before then, limp_o is 0 when run_o rises. Otherwise limp_o stays 1.
- R3: When the fallback is not allowed (pll_supply_i low or lh_disable_i high), limp_o and sel_vco_o are 0 from the next edge on, whatever the crystal does, and this also holds through reset.
- R4: xtal_active_i passes through a SYNC_STAGES-flop synchronizer (default 2). In run mode, a crystal loss raises limp_o on the third rising edge after the input falls, and not before.
- R5: In limp-home mode the crystal is checked on the FIRST_CHK-th edge after entry, then every RECHK edges.
- R6: Limp-home mode is left only on a check that finds activity and completes QUAL_N consecutive active checks. A check that finds no activity restarts the count. limp_o and sel_vco_o fall on that check edge.
- R7: In run mode with the fallback allowed, a crystal loss enters limp-home mode and restarts the R5 schedule from entry.
- R8: stop_req_i drops run_o on the next edge. On stop_wake_i with stop_dly_i=1, run_o returns after STARTUP_CYC edges. With stop_dly_i=0, run_o returns on the next edge, on the VCO if no activity is seen.
- R9: cop_rst_i drops run_o, restarts the release count and leaves limp_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running VCO clock |
| por_i | input | 1 | Power-on reset, active high |
| ext_rst_i | input | 1 | External reset, active high |
| cop_rst_i | input | 1 | Watchdog reset pulse |
| pll_supply_i | input | 1 | PLL supply present; allows the fallback |
| lh_disable_i | input | 1 | Software disable of the fallback |
| xtal_active_i | input | 1 | Asynchronous crystal activity indication |
| stop_req_i | input | 1 | Stop-mode entry request |
| stop_wake_i | input | 1 | Stop-mode exit event |
| stop_dly_i | input | 1 | Run the release count on stop exit |
| sel_vco_o | output | 1 | 1 selects the VCO clock, 0 the crystal |
| limp_o | output | 1 | Limp-home status flag |
| run_o | output | 1 | Core reset released and clock running |

## Verification
The hardest state to reach is a qualification run that is broken part way. It needs an active check, then an inactive check, then active ones again, and each must line up with a recheck instant that lies many cycles after entry. The bench keeps its own count of check instants from its reference model. It changes the crystal activity just after each check, and the synchronizer delay stays well inside the next interval. Crystal loss in run mode, a watchdog reset during limp-home, and both stop exits are driven in the same run. Every cycle is compared against the model.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  typedef enum logic [1:0] {
    ST_START = 2'd0,
    ST_RUN   = 2'd1,
    ST_LIMP  = 2'd2,
    ST_STOP  = 2'd3
  } lcs_state_e;
endpackage

// File: rtl/lcs_sync.sv
module lcs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES <= 1) begin : g_one
      logic q_r;
      always_ff @(posedge clk) begin
        if (rst) q_r <= 1'b0;
        else     q_r <= d_i;
      end
      assign q_o = q_r;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d_i};
      end
      assign q_o = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/lcs_startup_cnt.sv
module lcs_startup_cnt #(
  parameter int CNT_W = 13,
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic clr_i,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr_i)            cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt == LAST);
endmodule

// File: rtl/lcs_check_timer.sv
module lcs_check_timer #(
  parameter int FIRST_CHK = 4096,
  parameter int RECHK     = 8192
) (
  input  logic clk,
  input  logic rst,
  input  logic load_first_i,
  input  logic load_re_i,
  output logic expired_o
);
  localparam int MAXV  = (FIRST_CHK > RECHK) ? FIRST_CHK : RECHK;
  localparam int TMR_W = $clog2(MAXV) + 1;
  localparam logic [TMR_W-1:0] V_FIRST = TMR_W'(FIRST_CHK - 1);
  localparam logic [TMR_W-1:0] V_RE    = TMR_W'(RECHK - 1);

  logic [TMR_W-1:0] t;

  always_ff @(posedge clk) begin
    if (rst)               t <= '0;
    else if (load_first_i) t <= V_FIRST;
    else if (load_re_i)    t <= V_RE;
    else if (t != '0)      t <= t - 1'b1;
  end

  assign expired_o = (t == '0);
endmodule

// File: rtl/lcs_qualifier.sv
module lcs_qualifier #(
  parameter int QUAL_N = 1
) (
  input  logic clk,
  input  logic clr_i,
  input  logic hit_i,
  input  logic miss_i,
  output logic last_o
);
  localparam int QW = (QUAL_N > 1) ? $clog2(QUAL_N) : 1;
  localparam logic [QW-1:0] TOP = QW'(QUAL_N - 1);

  logic [QW-1:0] runs;

  always_ff @(posedge clk) begin
    if (clr_i || miss_i) runs <= '0;
    else if (hit_i)      runs <= (runs == TOP) ? '0 : runs + 1'b1;
  end

  // Next active check completes the qualification run
  assign last_o = (runs == TOP);
endmodule

// File: rtl/limp_clk_supervisor.sv
module limp_clk_supervisor
  import lcs_pkg::*;
#(
  parameter int CNT_W       = 13,
  parameter int STARTUP_CYC = 4096,
  parameter int FIRST_CHK   = 4096,
  parameter int RECHK       = 8192,
  parameter int QUAL_N      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_i,
  input  logic ext_rst_i,
  input  logic cop_rst_i,
  input  logic pll_supply_i,
  input  logic lh_disable_i,
  input  logic xtal_active_i,
  input  logic stop_req_i,
  input  logic stop_wake_i,
  input  logic stop_dly_i,
  output logic sel_vco_o,
  output logic limp_o,
  output logic run_o
);
  lcs_state_e st_q, st_d;
  logic limp_q, limp_d, run_q, run_d;
  logic rst_any, lh_ok, act_s;
  logic start_done, tmr_exp, q_last;
  logic cnt_clr, ld_first, ld_re, q_clr, hit, miss;

  assign rst_any = por_i | ext_rst_i;
  assign lh_ok   = pll_supply_i & ~lh_disable_i;

  lcs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst_any), .d_i (xtal_active_i), .q_o (act_s)
  );

  lcs_startup_cnt #(.CNT_W(CNT_W), .LIMIT(STARTUP_CYC)) u_start (
    .clk (clk), .clr_i (cnt_clr), .done_o (start_done)
  );

  lcs_check_timer #(.FIRST_CHK(FIRST_CHK), .RECHK(RECHK)) u_tmr (
    .clk (clk), .rst (rst_any), .load_first_i (ld_first),
    .load_re_i (ld_re), .expired_o (tmr_exp)
  );

  lcs_qualifier #(.QUAL_N(QUAL_N)) u_qual (
    .clk (clk), .clr_i (q_clr), .hit_i (hit), .miss_i (miss), .last_o (q_last)
  );

  always_comb begin
    st_d     = st_q;
    limp_d   = limp_q;
    run_d    = run_q;
    cnt_clr  = 1'b0;
    ld_first = 1'b0;
    ld_re    = 1'b0;
    q_clr    = 1'b0;
    hit      = 1'b0;
    miss     = 1'b0;
    if (rst_any) begin
      st_d    = ST_START;
      limp_d  = 1'b1;
      run_d   = 1'b0;
      cnt_clr = 1'b1;
      q_clr   = 1'b1;
    end else if (cop_rst_i) begin
      st_d    = ST_START;
      run_d   = 1'b0;
      cnt_clr = 1'b1;
    end else begin
      unique case (st_q)
        ST_START: begin
          if (act_s) limp_d = 1'b0;
          if (start_done) begin
            run_d = 1'b1;
            if (limp_d && lh_ok) begin
              st_d     = ST_LIMP;
              ld_first = 1'b1;
              q_clr    = 1'b1;
            end else begin
              st_d = ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (stop_req_i) begin
            st_d  = ST_STOP;
            run_d = 1'b0;
          end else if (lh_ok && !act_s) begin
            st_d     = ST_LIMP;
            limp_d   = 1'b1;
            ld_first = 1'b1;
            q_clr    = 1'b1;
          end
        end
        ST_LIMP: begin
          if (stop_req_i) begin
            st_d  = ST_STOP;
            run_d = 1'b0;
          end else if (!lh_ok) begin
            st_d = ST_RUN;
          end else if (tmr_exp) begin
            ld_re = 1'b1;
            if (act_s) begin
              hit = 1'b1;
              if (q_last) begin
                limp_d = 1'b0;
                st_d   = ST_RUN;
              end
            end else begin
              miss = 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (stop_wake_i) begin
            if (stop_dly_i) begin
              st_d    = ST_START;
              cnt_clr = 1'b1;
              limp_d  = 1'b1;
            end else begin
              run_d = 1'b1;
              if (lh_ok && !act_s) begin
                st_d     = ST_LIMP;
                limp_d   = 1'b1;
                ld_first = 1'b1;
                q_clr    = 1'b1;
              end else begin
                st_d   = ST_RUN;
                limp_d = 1'b0;
              end
            end
          end
        end
        default: st_d = ST_START;
      endcase
    end
    limp_d = limp_d & lh_ok;
  end

  always_ff @(posedge clk) begin
    st_q   <= st_d;
    limp_q <= limp_d;
    run_q  <= run_d;
  end

  assign sel_vco_o = limp_q;
  assign limp_o    = limp_q;
  assign run_o     = run_q;
endmodule

// File: rtl/limp_clk_supervisor_chk.sv
module limp_clk_supervisor_chk (
  input logic clk,
  input logic por_i,
  input logic ext_rst_i,
  input logic cop_rst_i,
  input logic pll_supply_i,
  input logic lh_disable_i,
  input logic xtal_active_i,
  input logic stop_req_i,
  input logic run_o,
  input logic limp_o
);
  logic lh_ok;
  assign lh_ok = pll_supply_i & ~lh_disable_i;

  a_r1_reset_holds_core: assert property (@(posedge clk) disable iff (por_i)
    ext_rst_i |=> (!run_o && (limp_o == $past(lh_ok))));

  a_r3_no_limp_when_disallowed: assert property (@(posedge clk) disable iff (por_i)
    !lh_ok |=> !limp_o);

  a_r8_stop_drops_run: assert property (@(posedge clk) disable iff (por_i)
    (stop_req_i && run_o && !ext_rst_i && !cop_rst_i) |=> !run_o);

  a_r9_cop_keeps_clock: assert property (@(posedge clk) disable iff (por_i)
    (cop_rst_i && !ext_rst_i && lh_ok) |=> (!run_o && $stable(limp_o)));

  a_r6_exit_needs_activity: assert property (@(posedge clk) disable iff (por_i)
    ($fell(limp_o) && !$past(ext_rst_i)) |-> ($past(xtal_active_i, 3) || !$past(lh_ok)));
endmodule

bind limp_clk_supervisor limp_clk_supervisor_chk chk_i (
  .clk           (clk),
  .por_i         (por_i),
  .ext_rst_i     (ext_rst_i),
  .cop_rst_i     (cop_rst_i),
  .pll_supply_i  (pll_supply_i),
  .lh_disable_i  (lh_disable_i),
  .xtal_active_i (xtal_active_i),
  .stop_req_i    (stop_req_i),
  .run_o         (run_o),
  .limp_o        (limp_o)
);

// File: tb/limp_clk_supervisor_tb_top.sv
module limp_clk_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int P_START = 16;
  localparam int P_FIRST = 16;
  localparam int P_RECHK = 32;
  localparam int P_QUAL  = 2;
  localparam int M_START = 0, M_RUN = 1, M_LIMP = 2, M_STOP = 3;

  logic clk = 1'b0;
  logic por = 1'b1, ext = 1'b0, cop = 1'b0, pll = 1'b1, dis = 1'b0;
  logic xtal = 1'b1, sreq = 1'b0, swake = 1'b0, sdly = 1'b0;
  logic sel_vco, limp, run;

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0, cmp_en = 0;
  string cur_req = "R1";

  // reference model state
  bit m1 = 0, m2 = 0, mlimp = 0, mrun = 0, act = 0, lhok = 0;
  int mmode = M_START, mage = 0, mqual = 0, mchecks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  limp_clk_supervisor #(
    .CNT_W(13), .STARTUP_CYC(P_START), .FIRST_CHK(P_FIRST),
    .RECHK(P_RECHK), .QUAL_N(P_QUAL), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .por_i(por), .ext_rst_i(ext), .cop_rst_i(cop),
    .pll_supply_i(pll), .lh_disable_i(dis), .xtal_active_i(xtal),
    .stop_req_i(sreq), .stop_wake_i(swake), .stop_dly_i(sdly),
    .sel_vco_o(sel_vco), .limp_o(limp), .run_o(run)
  );

  always @(posedge clk) begin
    cyc++;
    lhok = pll && !dis;
    act = m2; m2 = m1; m1 = xtal;
    if (por || ext) begin
      m1 = 0; m2 = 0; mmode = M_START; mage = 0; mrun = 0; mlimp = lhok; mqual = 0;
    end else if (cop) begin
      mmode = M_START; mage = 0; mrun = 0;
    end else begin
      case (mmode)
        M_START: begin
          if (act) mlimp = 0;
          mage++;
          if (mage == P_START) begin
            mrun = 1;
            if (mlimp && lhok) begin mmode = M_LIMP; mage = 0; mqual = 0; end
            else mmode = M_RUN;
          end
        end
        M_RUN: begin
          if (sreq) begin mmode = M_STOP; mrun = 0; end
          else if (lhok && !act) begin mmode = M_LIMP; mlimp = 1; mage = 0; mqual = 0; end
        end
        M_LIMP: begin
          if (sreq) begin mmode = M_STOP; mrun = 0; end
          else if (!lhok) mmode = M_RUN;
          else begin
            mage++;
            if (mage == P_FIRST || (mage > P_FIRST && (mage - P_FIRST) % P_RECHK == 0)) begin
              mchecks++;
              if (act) begin
                mqual++;
                if (mqual == P_QUAL) begin mlimp = 0; mmode = M_RUN; mqual = 0; end
              end else mqual = 0;
            end
          end
        end
        default: begin
          if (swake) begin
            if (sdly) begin mmode = M_START; mage = 0; mlimp = 1; end
            else begin
              mrun = 1;
              if (lhok && !act) begin mmode = M_LIMP; mlimp = 1; mage = 0; mqual = 0; end
              else begin mmode = M_RUN; mlimp = 0; end
            end
          end
        end
      endcase
    end
    mlimp = mlimp && lhok;
    cmp_en = 1;
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      tests++;
      if (run !== mrun || limp !== mlimp || sel_vco !== mlimp) begin
        fails++;
        $display("FAIL %s cycle %0d: run/limp/sel=%b%b%b expected %b%b%b",
                 cur_req, cyc, run, limp, sel_vco, mrun, mlimp, mlimp);
      end
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic got, input logic exp, input string what);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic wait_check();
    int c0 = mchecks;
    while (mchecks == c0) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    step(4);
    check("R1", run, 1'b0, "run in reset");
    check("R1", limp, 1'b1, "limp in reset");
    // R2: normal start with active crystal
    cur_req = "R2";
    por = 1'b0;
    step(P_START - 2);
    check("R2", run, 1'b0, "run before count end");
    step(4);
    check("R2", run, 1'b1, "run after count");
    check("R2", limp, 1'b0, "crystal selected");

    // R2/R5/R6: slow crystal start
    cur_req = "R5";
    xtal = 1'b0; ext = 1'b1;
    step(3);
    ext = 1'b0;
    step(P_START + 2);
    check("R2", limp, 1'b1, "limp after slow start");
    check("R2", run, 1'b1, "core runs on vco");
    wait_check();                       // first check, inactive
    check("R5", limp, 1'b1, "still limp after idle check");
    cur_req = "R6";
    xtal = 1'b1;
    wait_check();                       // active 1 of 2
    check("R6", limp, 1'b1, "one active check not enough");
    xtal = 1'b0;
    wait_check();                       // inactive: count restarts
    xtal = 1'b1;
    wait_check();                       // active 1 of 2 again
    check("R6", limp, 1'b1, "count restarted by idle check");
    wait_check();                       // active 2 of 2
    check("R6", limp, 1'b0, "left limp after qualified run");
    check("R6", sel_vco, 1'b0, "crystal selected after exit");

    // R4/R7: crystal loss in run mode
    cur_req = "R7";
    step(3);
    xtal = 1'b0;
    step(2);
    check("R4", limp, 1'b0, "sync delay before limp");
    step(1);
    check("R4", limp, 1'b1, "limp on third edge");
    wait_check();
    check("R7", limp, 1'b1, "idle recheck keeps limp");
    xtal = 1'b1;
    wait_check();
    wait_check();
    check("R7", limp, 1'b0, "recovered after loss");

    // R8: stop with delay
    cur_req = "R8";
    sreq = 1'b1; step(1); sreq = 1'b0;
    check("R8", run, 1'b0, "stop drops run");
    step(5);
    swake = 1'b1; sdly = 1'b1; step(1); swake = 1'b0; sdly = 1'b0;
    step(P_START - 6);
    check("R8", run, 1'b0, "delay count running");
    step(6);
    check("R8", run, 1'b1, "run after delay");
    check("R8", limp, 1'b0, "crystal after delayed wake");
    // R8: stop without delay
    sreq = 1'b1; step(1); sreq = 1'b0;
    step(4);
    swake = 1'b1; step(1); swake = 1'b0;
    check("R8", run, 1'b1, "run next edge without delay");
    check("R8", limp, 1'b0, "crystal after direct wake");

    // R9: watchdog reset while in limp
    cur_req = "R9";
    xtal = 1'b0;
    step(5);
    check("R9", limp, 1'b1, "limp before cop");
    cop = 1'b1; step(1); cop = 1'b0;
    check("R9", run, 1'b0, "cop drops run");
    check("R9", limp, 1'b1, "cop keeps limp");
    step(P_START + 1);
    check("R9", run, 1'b1, "run after cop count");
    check("R9", limp, 1'b1, "still on vco");

    // R3: fallback disallowed
    cur_req = "R3";
    dis = 1'b1;
    step(1);
    check("R3", limp, 1'b0, "disable clears limp");
    step(40);
    check("R3", sel_vco, 1'b0, "no limp with dead crystal");
    ext = 1'b1; step(3);
    check("R3", limp, 1'b0, "no limp in reset when disabled");
    ext = 1'b0;
    step(P_START + 2);
    check("R3", run, 1'b1, "start completes on crystal");
    dis = 1'b0; pll = 1'b0;
    step(10);
    check("R3", limp, 1'b0, "no limp without pll supply");

    step(2);
    finish_run();
  end
endmodule